// File: doc/BRIEF.md
# Zero-Set Compare-Reset Pulse-Width Modulator

This block makes a rectangular waveform whose high time can be set in steps of one count of a free-running up-counter. The counter is `CNT_W` bits wide (16 by default), so one period is 2^CNT_W counting ticks. A zero detector turns the output on when the counter rolls over to zero. An equality match between the counter and the active width value turns it off. As a result, the width value is the number of counts for which the output is high in each period.

The counter moves only on cycles where the tick enable is high. A prescaler outside the block drives this enable, and slowing it stretches the period by the same factor. Width writes first go into a holding register. The holding register is copied into the active comparator value only at the rollover, so a period never mixes two widths. A separate full-duty control holds the output high without a break, which the compare path alone cannot do.

Top module: `pwm_zero_set`

## Requirements
- R1: Out of reset the counter holds all ones. The first enabled tick therefore moves it to zero, and the output is high from the following clock edge onward.
- R2: With width value N (1 ≤ N ≤ 2^CNT_W − 1) and one tick per clock, the output is high for exactly N consecutive counts (counter values 0 to N−1) out of every 2^CNT_W, and low for the rest.
- R3: A width value of 0 keeps the output low for the entire period. When the zero-detect set and the compare clear fall on the same tick, the clear wins.
- R4: A width value of 1 gives exactly one high count per period.
- R5: A width value of 2^(CNT_W−1) gives exactly half the period high (50% duty).
- R6: While the full-duty input is high, the output is high one clock later and stays high, whatever the width value. When the input is released, the output goes back to the compare waveform.
- R7: In cycles where the tick enable is low, the counter and the output latch hold their values. If full-duty is also low, the output does not change.
- R8: If a tick arrives only every k-th clock, the period and the high time both stretch by the factor k. With k = 2, a width of N gives 2N high clocks in every 2·2^CNT_W clocks.
- R9: A width write goes to a holding register. The holding register is copied into the active compare value only on the tick that rolls the counter over to zero, so the period that is running keeps its old width.
- R10: While reset is asserted, the output is low, and the active and holding width values both become 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_en | input | 1 | Counting enable; the counter advances one count on each clock where it is high |
| wr_en | input | 1 | Write strobe for the width holding register |
| wr_width | input | CNT_W | Width value to write |
| full_duty | input | 1 | Forces the output high continuously |
| pwm_o | output | 1 | Registered PWM output |

## Verification
The embedded assertions check four things on every clock: the counter and the active width stay frozen when no tick or rollover occurs, a compare match always clears the output, a zero width never lets the output rise at rollover, and the full-duty control wins. Some behaviours only show up over a whole period, so only the bench's scenarios can demonstrate them. These are the exact high count for each width value, the stretching of the period when ticks are sparse, the first rising edge after reset, and the fact that a mid-period write changes nothing until the next rollover.

// File: rtl/pwm_zs_pkg.sv
package pwm_zs_pkg;

   typedef enum logic [1:0] {
      LATCH_HOLD  = 2'd0,
      LATCH_SET   = 2'd1,
      LATCH_CLEAR = 2'd2
   } latch_act_e;

   function automatic logic [31:0] all_ones(input int unsigned w);
      logic [31:0] v;
      v = '0;
      for (int unsigned i = 0; i < 32; i++) begin
         if (i < w) v[i] = 1'b1;
      end
      return v;
   endfunction

endpackage

// File: rtl/pwm_zs_counter.sv
module pwm_zs_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   output logic [CNT_W-1:0] next_o,
   output logic             wrap_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(pwm_zs_pkg::all_ones(CNT_W));

   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("pwm_zs_counter: CNT_W must be 2..32");
      end
   endgenerate

   assign next_o = cnt_q + CNT_W'(1);
   assign wrap_o = tick_i && (cnt_q == CNT_MAX);

   always_ff @(posedge clk) begin
      if (rst)         cnt_q <= CNT_MAX;
      else if (tick_i) cnt_q <= next_o;
   end

   assert_count_holds_R7: assert property (@(posedge clk) disable iff (rst)
      !tick_i |=> $stable(cnt_q));

endmodule

// File: rtl/pwm_zs_width.sv
module pwm_zs_width #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_width_i,
   input  logic             load_i,
   output logic [CNT_W-1:0] cmp_o
);
   logic [CNT_W-1:0] hold_q;
   logic [CNT_W-1:0] active_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_q   <= '0;
         active_q <= '0;
      end else begin
         if (wr_en_i) hold_q <= wr_width_i;
         if (load_i)  active_q <= hold_q;
      end
   end

   // on the rollover tick the new width already governs count zero
   assign cmp_o = load_i ? hold_q : active_q;

   assert_active_only_at_wrap_R9: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> $stable(active_q));

endmodule

// File: rtl/pwm_zs_out.sv
module pwm_zs_out #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] next_i,
   input  logic [CNT_W-1:0] cmp_i,
   input  logic             full_i,
   output logic             pwm_o
);
   import pwm_zs_pkg::*;

   latch_act_e act;
   logic       lat_q;
   logic       lat_d;
   logic       out_q;

   always_comb begin
      act = LATCH_HOLD;
      if (tick_i) begin
         if (next_i == cmp_i) act = LATCH_CLEAR;
         else if (wrap_i)     act = LATCH_SET;
      end
      unique case (act)
         LATCH_SET:   lat_d = 1'b1;
         LATCH_CLEAR: lat_d = 1'b0;
         default:     lat_d = lat_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         lat_q <= 1'b0;
         out_q <= 1'b0;
      end else begin
         lat_q <= lat_d;
         out_q <= full_i | lat_d;
      end
   end

   assign pwm_o = out_q;

   assert_full_duty_high_R6: assert property (@(posedge clk) disable iff (rst)
      full_i |=> pwm_o);

   assert_match_clears_R2: assert property (@(posedge clk) disable iff (rst)
      (tick_i && next_i == cmp_i && !full_i) |=> !pwm_o);

   assert_zero_width_low_R3: assert property (@(posedge clk) disable iff (rst)
      (wrap_i && cmp_i == '0 && !full_i) |=> !pwm_o);

endmodule

// File: rtl/pwm_zero_set.sv
module pwm_zero_set #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_en,
   input  logic             wr_en,
   input  logic [CNT_W-1:0] wr_width,
   input  logic             full_duty,
   output logic             pwm_o
);
   logic [CNT_W-1:0] next_cnt;
   logic             wrap;
   logic [CNT_W-1:0] cmp_width;

   pwm_zs_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .tick_i(tick_en),
      .next_o(next_cnt), .wrap_o(wrap)
   );

   pwm_zs_width #(.CNT_W(CNT_W)) u_width (
      .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_width_i(wr_width),
      .load_i(wrap), .cmp_o(cmp_width)
   );

   pwm_zs_out #(.CNT_W(CNT_W)) u_out (
      .clk(clk), .rst(rst), .tick_i(tick_en), .wrap_i(wrap),
      .next_i(next_cnt), .cmp_i(cmp_width), .full_i(full_duty),
      .pwm_o(pwm_o)
   );

   assert_reset_low_R10: assert property (@(posedge clk)
      rst |=> !pwm_o);

endmodule

// File: tb/pwm_zero_set_test.sv
`timescale 1ns/1ps
module pwm_zero_set_test;
   localparam int W      = 8;
   localparam int PERIOD = 1 << W;

   logic         clk = 1'b0;
   logic         rst;
   logic         tick_en;
   logic         wr_en;
   logic [W-1:0] wr_width;
   logic         full_duty;
   logic         pwm_o;

   int errors = 0;
   int checks = 0;
   int bcnt   = PERIOD - 1;
   bit done   = 0;

   always #2.5 clk = ~clk;

   pwm_zero_set #(.CNT_W(W)) uut (
      .clk(clk), .rst(rst), .tick_en(tick_en), .wr_en(wr_en),
      .wr_width(wr_width), .full_duty(full_duty), .pwm_o(pwm_o)
   );

   // width under test and expected high count per period (R2, R3, R4, R5)
   localparam int NVEC = 6;
   localparam int VEC_W   [NVEC] = '{0, 1, 128, 255, 37, 3};
   localparam int VEC_EXP [NVEC] = '{0, 1, 128, 255, 37, 3};
   localparam string VEC_R [NVEC] = '{"R3", "R4", "R5", "R2", "R2", "R2"};

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step(input logic t);
      tick_en = t;
      @(posedge clk);
      if (t && !rst) bcnt = (bcnt + 1) % PERIOD;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic write_w(input int w, input logic t);
      wr_en    = 1'b1;
      wr_width = W'(w);
      step(t);
   endtask

   task automatic to_wrap();
      step(1'b1);
      while (bcnt != 0) step(1'b1);
   endtask

   // samples counts 0..PERIOD-1, starting just after a rollover
   task automatic measure(output int highs);
      highs = 0;
      for (int i = 0; i < PERIOD; i++) begin
         if (i != 0) step(1'b1);
         highs += int'(pwm_o);
      end
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      int h;
      rst = 1'b1; tick_en = 1'b0; wr_en = 1'b0; wr_width = '0; full_duty = 1'b0;
      @(negedge clk); step(1'b1); step(1'b1);
      chk("R10 reset low", int'(pwm_o), 0);
      rst = 1'b0;
      bcnt = PERIOD - 1;

      // R1: width 3 written while idle, first tick rises output
      write_w(3, 1'b0);
      step(1'b0);
      chk("R1 idle before tick", int'(pwm_o), 0);
      step(1'b1);
      chk("R1 high on first tick", int'(pwm_o), 1);
      step(1'b1); chk("R2 count1 high", int'(pwm_o), 1);
      step(1'b1); chk("R2 count2 high", int'(pwm_o), 1);
      step(1'b1); chk("R2 count3 low", int'(pwm_o), 0);

      // table of widths
      for (int v = 0; v < NVEC; v++) begin
         write_w(VEC_W[v], 1'b1);
         to_wrap();
         measure(h);
         chk(VEC_R[v], h, VEC_EXP[v]);
      end

      // R9: mid-period write deferred to rollover
      write_w(200, 1'b1);
      to_wrap();
      while (bcnt != 50) step(1'b1);
      write_w(5, 1'b1);
      while (bcnt != 150) step(1'b1);
      chk("R9 old width still active", int'(pwm_o), 1);
      to_wrap();
      measure(h);
      chk("R9 new width next period", h, 5);

      // R7: ticks off hold output, high and low phases
      write_w(100, 1'b1);
      to_wrap();
      while (bcnt != 20) step(1'b1);
      h = 0;
      for (int i = 0; i < 30; i++) begin step(1'b0); h += int'(pwm_o); end
      chk("R7 hold while high", h, 30);
      while (bcnt != 180) step(1'b1);
      h = 0;
      for (int i = 0; i < 30; i++) begin step(1'b0); h += int'(pwm_o); end
      chk("R7 hold while low", h, 0);

      // R8: tick every second clock doubles the period
      write_w(37, 1'b1);
      to_wrap();
      to_wrap();
      h = 0;
      for (int i = 0; i < PERIOD; i++) begin
         if (i != 0) step(1'b1);
         h += int'(pwm_o);
         step(1'b0);
         h += int'(pwm_o);
      end
      chk("R8 half rate highs", h, 74);

      // R6: full duty beats width 0, then releases
      write_w(0, 1'b1);
      to_wrap();
      full_duty = 1'b1;
      step(1'b1);
      chk("R6 high after one clock", int'(pwm_o), 1);
      h = 0;
      for (int i = 0; i < PERIOD; i++) begin step(1'b1); h += int'(pwm_o); end
      chk("R6 whole period high", h, PERIOD);
      full_duty = 1'b0;
      step(1'b1);
      chk("R6 release to width 0", int'(pwm_o), 0);
      write_w(10, 1'b1);
      to_wrap();
      measure(h);
      chk("R6 waveform resumes", h, 10);

      // R10: reset mid-period clears output and widths
      while (bcnt != 3) step(1'b1);
      rst = 1'b1;
      step(1'b1);
      chk("R10 low in reset", int'(pwm_o), 0);
      rst = 1'b0;
      bcnt = PERIOD - 1;
      step(1'b1);
      chk("R10 width cleared, stays low", int'(pwm_o), 0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule